// File: doc/BRIEF.md
# Double-Buffer Address Manager

This block keeps the pointers that split a downstream memory into two halves, one being filled while the other is consumed. It holds a base, an offset and an input-top value. It receives one-cycle command strobes from an upstream decoder: set base, set offset, set input-top, start program and continue program. From these it derives the current fill pointer and a buffer flag, which is the status bit that says which half is active.

A start or continue command is a program launch, and it needs the downstream unit to be idle. If the unit is busy, the block parks the command internally and retries it on every cycle until the unit goes idle. Each launch does four things:

- toggles the buffer flag;
- moves the fill pointer to base plus flag times offset;
- hands the input-top value and the new fill pointer to the downstream unit;
- raises a one-cycle launch strobe.

Continue differs from start in one respect: it tells the downstream unit to resume at its own program counter rather than at a new start address.

Top module: `dbuf_addr_mgr`

## Requirements
- R1: After a synchronous reset, the following are all zero: the fill pointer, the buffer flag, both handed-off tops, the launch strobe, the resume flag, the launch address and the pending flag.
- R2: Set-base (code 1) loads the base register from the low 10 bits of the immediate. On the next cycle the fill pointer equals that value and the buffer flag is 0.
- R3: Set-offset (code 2) loads the offset register from the low 10 bits of the immediate. It clears the buffer flag, even when the flag was 1, and sets the fill pointer equal to the current base.
- R4: Set-input-top (code 3) loads the input-top register from the low 10 bits of the immediate. The handed-off input-top output keeps its old value until the next launch.
- R5: A start command (code 4) issued while `sink_idle` is high produces a one-cycle `launch` pulse on the next cycle. In that cycle `launch_addr` equals the 16-bit immediate and `launch_resume` is 0.
- R6: A launch command issued while `sink_idle` is low raises `launch_pending` and leaves all pointers unchanged. At the first clock edge where `sink_idle` is high, the command fires with its original immediate, and `launch` is never high unless `sink_idle` was high at the edge before.
- R7: Each launch toggles the buffer flag. The new fill pointer is base + offset when the new flag is 1, and base alone when the new flag is 0.
- R8: In the cycle `launch` is high, `top_out` equals the new fill pointer and `itop_out` equals the input-top register.
- R9: A continue command (code 5) performs the same pointer update as start, with `launch_resume` set to 1.
- R10: The fill-pointer sum is 10 bits wide and wraps modulo 1024.
- R11: Codes 0, 6 and 7 have no effect. Any command strobe that arrives while a launch is pending is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command type (1 base, 2 offset, 3 input-top, 4 start, 5 continue) |
| cmd_imm | input | 16 | Command immediate |
| sink_idle | input | 1 | Downstream unit is idle |
| fill_ptr | output | 10 | Current fill pointer |
| buf_flag | output | 1 | Active-half flag, status mirror |
| top_out | output | 10 | Handed-off top pointer |
| itop_out | output | 10 | Handed-off input-top |
| launch | output | 1 | One-cycle program launch strobe |
| launch_resume | output | 1 | Launch resumes at the downstream program counter |
| launch_addr | output | 16 | Program start address for the launch |
| launch_pending | output | 1 | A launch waits for the downstream unit |

## Verification
Several properties are checked on every cycle:

- a launch never fires unless the downstream unit was idle;
- every launch toggles the flag;
- the new fill pointer obeys the base-plus-flag-times-offset rule;
- the handed-off top matches the fill pointer;
- pointers hold while a launch is parked;
- set-base and set-offset clear the flag.

The directed scenarios cover what the properties cannot express. These are the truncation of the immediates to 10 bits and the deferred visibility of the input-top value. They also cover the exact immediate carried by a retried launch, the discarding of commands during a pending launch, and the modulo-1024 wrap.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_SET_BASE = 3'd1,
    CMD_SET_OFS  = 3'd2,
    CMD_SET_ITOP = 3'd3,
    CMD_START    = 3'd4,
    CMD_CONT     = 3'd5
  } dbuf_cmd_e;
endpackage

// File: rtl/dbuf_cfg_regs.sv
module dbuf_cfg_regs #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_base,
  input  logic             wr_ofs,
  input  logic             wr_itop,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] base_q,
  output logic [PTR_W-1:0] ofs_q,
  output logic [PTR_W-1:0] itop_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ofs_q  <= '0;
      itop_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_ofs)  ofs_q  <= wdata;
      if (wr_itop) itop_q <= wdata;
    end
  end
endmodule

// File: rtl/dbuf_ptr_unit.sv
module dbuf_ptr_unit #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PTR_W-1:0] clr_ptr,
  input  logic             adv,
  input  logic [PTR_W-1:0] base_i,
  input  logic [PTR_W-1:0] ofs_i,
  output logic [PTR_W-1:0] fill_nxt,
  output logic             flag_q,
  output logic [PTR_W-1:0] fill_q
);
  // Next half: after toggling, the flag selects whether offset is added.
  always_comb begin
    fill_nxt = base_i + (flag_q ? '0 : ofs_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      fill_q <= '0;
    end else if (clr) begin
      flag_q <= 1'b0;
      fill_q <= clr_ptr;
    end else if (adv) begin
      flag_q <= ~flag_q;
      fill_q <= fill_nxt;
    end
  end

  assert_clr_flag_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!flag_q && fill_q == $past(clr_ptr)));

  assert_adv_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (flag_q != $past(flag_q)));

  assert_adv_sum_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (fill_q == PTR_W'($past(base_i) + (flag_q ? $past(ofs_i) : PTR_W'(0)))));
endmodule

// File: rtl/dbuf_launch.sv
module dbuf_launch #(
  parameter int PTR_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              resume_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PTR_W-1:0]  top_i,
  input  logic [PTR_W-1:0]  itop_i,
  output logic              launch_q,
  output logic              resume_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [PTR_W-1:0]  top_q,
  output logic [PTR_W-1:0]  itop_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      launch_q <= 1'b0;
      resume_q <= 1'b0;
      addr_q   <= '0;
      top_q    <= '0;
      itop_q   <= '0;
    end else begin
      launch_q <= fire;
      if (fire) begin
        resume_q <= resume_i;
        addr_q   <= addr_i;
        top_q    <= top_i;
        itop_q   <= itop_i;
      end
    end
  end

  assert_itop_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(itop_q));
endmodule

// File: rtl/dbuf_addr_mgr.sv
module dbuf_addr_mgr
  import dbuf_pkg::*;
#(
  parameter int PTR_W  = 10,
  parameter int IMM_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic              sink_idle,
  output logic [PTR_W-1:0]  fill_ptr,
  output logic              buf_flag,
  output logic [PTR_W-1:0]  top_out,
  output logic [PTR_W-1:0]  itop_out,
  output logic              launch,
  output logic              launch_resume,
  output logic [IMM_W-1:0]  launch_addr,
  output logic              launch_pending
);
  logic             pend_q, pend_res_q;
  logic [IMM_W-1:0] pend_addr_q;
  logic             cfg_ok, new_launch, eff_launch, eff_resume, fire;
  logic [IMM_W-1:0] eff_addr;
  logic             wr_base, wr_ofs, wr_itop;
  logic [PTR_W-1:0] imm_lo, base_q, ofs_q, itop_q, fill_nxt, clr_ptr;

  assign imm_lo = cmd_imm[PTR_W-1:0];

  always_comb begin
    cfg_ok     = cmd_valid && !pend_q;
    wr_base    = cfg_ok && (cmd_code == CMD_SET_BASE);
    wr_ofs     = cfg_ok && (cmd_code == CMD_SET_OFS);
    wr_itop    = cfg_ok && (cmd_code == CMD_SET_ITOP);
    new_launch = cfg_ok && (cmd_code == CMD_START || cmd_code == CMD_CONT);
    eff_launch = pend_q || new_launch;
    eff_resume = pend_q ? pend_res_q : (cmd_code == CMD_CONT);
    eff_addr   = pend_q ? pend_addr_q : cmd_imm;
    fire       = eff_launch && sink_idle;
    clr_ptr    = wr_base ? imm_lo : base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_res_q  <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_q <= eff_launch && !sink_idle;
      if (new_launch) begin
        pend_res_q  <= (cmd_code == CMD_CONT);
        pend_addr_q <= cmd_imm;
      end
    end
  end

  dbuf_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_base(wr_base), .wr_ofs(wr_ofs), .wr_itop(wr_itop),
    .wdata(imm_lo), .base_q(base_q), .ofs_q(ofs_q), .itop_q(itop_q)
  );

  dbuf_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .clr(wr_base || wr_ofs), .clr_ptr(clr_ptr), .adv(fire),
    .base_i(base_q), .ofs_i(ofs_q), .fill_nxt(fill_nxt), .flag_q(buf_flag), .fill_q(fill_ptr)
  );

  dbuf_launch #(.PTR_W(PTR_W), .ADDR_W(IMM_W)) u_launch (
    .clk(clk), .rst(rst), .fire(fire), .resume_i(eff_resume), .addr_i(eff_addr),
    .top_i(fill_nxt), .itop_i(itop_q), .launch_q(launch), .resume_q(launch_resume),
    .addr_q(launch_addr), .top_q(top_out), .itop_q(itop_out)
  );

  assign launch_pending = pend_q;

  assert_idle_before_launch_R6: assert property (@(posedge clk) disable iff (rst)
    launch |-> $past(sink_idle));

  assert_hold_while_parked_R6: assert property (@(posedge clk) disable iff (rst)
    (launch_pending && !sink_idle) |=> ($stable(fill_ptr) && $stable(buf_flag) && !launch));

  assert_top_matches_fill_R8: assert property (@(posedge clk) disable iff (rst)
    launch |-> (top_out == fill_ptr));

  assert_flag_flips_R7: assert property (@(posedge clk) disable iff (rst)
    launch |-> (buf_flag != $past(buf_flag)));
endmodule

// File: tb/dbuf_addr_mgr_bench.sv
module dbuf_addr_mgr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [15:0] cmd_imm = '0;
  logic        sink_idle = 1'b1;
  logic [9:0]  fill_ptr, top_out, itop_out;
  logic        buf_flag, launch, launch_resume, launch_pending;
  logic [15:0] launch_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model of the architectural state
  logic [9:0] m_base = '0, m_ofs = '0, m_itop = '0, m_fill = '0;
  logic       m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_addr_mgr u_dbuf_addr_mgr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_imm(cmd_imm),
    .sink_idle(sink_idle), .fill_ptr(fill_ptr), .buf_flag(buf_flag), .top_out(top_out),
    .itop_out(itop_out), .launch(launch), .launch_resume(launch_resume),
    .launch_addr(launch_addr), .launch_pending(launch_pending)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Drive one command strobe; return just after the edge that consumes it.
  task automatic send(input logic [2:0] code, input logic [15:0] imm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_imm = imm;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  // Model of a launch
  task automatic model_launch();
    m_flag = ~m_flag;
    m_fill = m_base + (m_flag ? m_ofs : 10'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "fill", fill_ptr, 0);
    chk("R1", "flag", buf_flag, 0);
    chk("R1", "top", top_out, 0);
    chk("R1", "itop", itop_out, 0);
    chk("R1", "launch", launch, 0);
    chk("R1", "resume", launch_resume, 0);
    chk("R1", "addr", launch_addr, 0);
    chk("R1", "pending", launch_pending, 0);
  endtask

  task automatic t_config();
    send(3'd1, 16'hF2A5); m_base = 10'h2A5; m_fill = m_base; m_flag = 0;
    chk("R2", "fill after set-base", fill_ptr, m_fill);
    chk("R2", "flag after set-base", buf_flag, 0);
    send(3'd2, 16'h84C8); m_ofs = 10'h0C8; m_fill = m_base;
    chk("R3", "fill after set-offset", fill_ptr, m_fill);
    chk("R3", "flag after set-offset", buf_flag, 0);
    send(3'd3, 16'h5523); m_itop = 10'h123;
    chk("R4", "itop_out before launch", itop_out, 0);
    idle_cycle();
    chk("R4", "itop_out still held", itop_out, 0);
  endtask

  task automatic t_start_idle();
    send(3'd4, 16'hBEEF); model_launch();
    chk("R5", "launch", launch, 1);
    chk("R5", "addr", launch_addr, 16'hBEEF);
    chk("R5", "resume", launch_resume, 0);
    chk("R7", "flag", buf_flag, m_flag);
    chk("R7", "fill", fill_ptr, m_fill);
    chk("R8", "top", top_out, m_fill);
    chk("R8", "itop", itop_out, m_itop);
    idle_cycle();
    chk("R5", "launch one cycle", launch, 0);
  endtask

  task automatic t_continue();
    send(3'd5, 16'h0777); model_launch();
    chk("R9", "launch", launch, 1);
    chk("R9", "resume", launch_resume, 1);
    chk("R7", "flag back to 0", buf_flag, m_flag);
    chk("R7", "fill equals base", fill_ptr, m_fill);
    chk("R8", "top", top_out, m_fill);
  endtask

  task automatic t_busy_retry();
    @(negedge clk); sink_idle = 1'b0;
    send(3'd4, 16'h1234);
    chk("R6", "no launch while busy", launch, 0);
    chk("R6", "pending", launch_pending, 1);
    chk("R6", "fill held", fill_ptr, m_fill);
    send(3'd1, 16'h0001);
    chk("R11", "set-base during pending dropped", fill_ptr, m_fill);
    idle_cycle();
    chk("R6", "still no launch", launch, 0);
    chk("R6", "flag held", buf_flag, m_flag);
    @(negedge clk); sink_idle = 1'b1;
    @(posedge clk); #1; model_launch();
    chk("R6", "retried launch", launch, 1);
    chk("R6", "retried addr", launch_addr, 16'h1234);
    chk("R6", "resume of start", launch_resume, 0);
    chk("R11", "fill uses old base", fill_ptr, m_fill);
    chk("R6", "pending cleared", launch_pending, 0);
  endtask

  task automatic t_wrap();
    send(3'd1, 16'h03F0); m_base = 10'h3F0; m_fill = m_base; m_flag = 0;
    send(3'd2, 16'h0020); m_ofs = 10'h020;
    send(3'd4, 16'h0042); model_launch();
    chk("R10", "wrapped fill", fill_ptr, 10'h010);
    chk("R10", "wrapped top", top_out, 10'h010);
    send(3'd2, 16'h0020); m_flag = 0; m_fill = m_base;
    chk("R3", "offset clears set flag", buf_flag, 0);
    chk("R3", "fill back to base", fill_ptr, 10'h3F0);
  endtask

  task automatic t_unknown();
    send(3'd7, 16'hFFFF);
    chk("R11", "code 7 fill", fill_ptr, m_fill);
    chk("R11", "code 7 launch", launch, 0);
    send(3'd0, 16'h0155);
    chk("R11", "code 0 fill", fill_ptr, m_fill);
    send(3'd6, 16'h0155);
    chk("R11", "code 6 flag", buf_flag, m_flag);
    chk("R11", "code 6 pending", launch_pending, 0);
  endtask

  initial begin
    t_reset();
    t_config();
    t_start_idle();
    t_continue();
    t_busy_retry();
    t_wrap();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule